// File: doc/BRIEF.md
# Full-Duplex Byte Serial Port with Write-Collision Detection

This block is an 8-bit synchronous serial port that exchanges one byte in each direction per transfer. It can be the master, in which case it generates the serial clock from the system clock through a programmable divider. It can also be the slave, in which case it follows an external serial clock and, if configured, an active-low select input. Software reaches it through three byte-wide registers: a control register, a status register and a data register. A fourth shift stage inside the block cannot be reached by software.

Receive is double-buffered. A finished byte moves from the shift stage into the data register, which sets a buffer-full bit and a level interrupt flag, and the next byte can start shifting in at once. Transmit is single-buffered. Writing the data register loads the data register and the shift stage together, and in master mode it also starts the transfer. A write made while a transfer is in progress is discarded and sets a sticky collision bit that only software clears.

Top module: `spi_port`

## Requirements
- R1: Each transfer moves exactly 8 bits out on `sdo_o` and 8 bits in from the data input, most significant bit first, both at once.
- R2: Clock polarity (control bit 4) sets the idle level of the serial clock. With phase (status bit 6) at 0, each output bit is valid before the leading clock edge and changes on the trailing edge. With phase at 1, each output bit changes on the leading edge and is valid at the trailing edge.
- R3: In master mode, the late-sample bit (status bit 7) moves the input sample point half a clock period later: onto the output-change edge, or onto one extra half period after the last edge. With `sdo_o` looped back to the data input, the received byte equals the sent byte for all eight combinations of polarity, phase and late sample.
- R4: In master mode (control bit 5 = enable set, bit 3 = slave clear), `sck_oe` is high. Each half period of the serial clock lasts `DIV_BASE << div` system clocks, where div is control bits 1:0. A transfer makes exactly 16 clock edges, and the clock rests at the polarity level whenever no transfer is running.
- R5: In master mode, a write to the data register (address 2) while idle starts a transfer, and status bit 1 (busy) reads 1 while the transfer runs.
- R6: When a byte completes, it is copied into the data register and status bit 0 (buffer full) and the interrupt flag (`irq_o`, also status bit 2) are set. A read of address 2 clears both.
- R7: If a byte completes while buffer full is still set, control bit 6 (overflow) is set and the data register keeps its previous contents.
- R8: A write to address 2 while busy is discarded and sets control bit 7 (collision). The bit stays set until software writes it to 0 through address 0.
- R9: Address 0 (control) reads back all 8 bits as written. At address 1 (status), only bits 7:6 are writable. Bits 5:0 are read-only and are zero when the port is idle with nothing buffered.
- R10: In slave mode (control bit 3 set), the port follows an external clock on `sck_i` and exchanges a preloaded byte for an incoming byte in all four clock modes.
- R11: In slave mode with select use (control bit 2) set, while `ss_n_i` is high, `sdo_oe` is low and the bit and edge counters return to zero, so that a byte cut off part-way is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of data clears buffer full and the flag) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_o | output | 1 | Byte-complete interrupt flag |
| sck_i | input | 1 | Serial clock input (slave mode) |
| sck_o | output | 1 | Serial clock output (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| ss_n_i | input | 1 | Active-low slave select |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
The assertions assume that software changes the polarity, phase, sample and mode settings only while no transfer is running, and that in slave mode each level of the external clock lasts longer than the synchronizer delay. The bench changes the configuration only with the port idle, and it turns the port off before it moves the external clock to a new idle level. It drives the slave clock with half periods of six system clocks and changes its data input only on its own output-change edges.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    // Control register layout; collision flag sits in the top bit.
    typedef struct packed {
        logic       wcol;
        logic       ovf;
        logic       en;
        logic       cpol;
        logic       slave;
        logic       use_ss;
        logic [1:0] div_sel;
    } ctrl_t;

    // One serial clock event, shared by the master generator and slave front end.
    typedef struct packed {
        logic lead;
        logic trail;
        logic fin;
    } sck_ev_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

endpackage

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen
    import spi_port_pkg::*;
#(
    parameter int W        = 8,
    parameter int DIV_BASE = 1,
    parameter int DIVW     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       start,
    input  logic       cpol,
    input  logic [1:0] div_sel,
    output logic       sck,
    output logic       busy,
    output sck_ev_t    ev
);
    localparam int CW    = DIVW + 3;
    localparam int TICKS = 2 * W;
    localparam int TW    = $clog2(TICKS + 1);

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic [CW-1:0] cnt;
        logic [TW-1:0] tick;
    } gen_t;

    gen_t st_d, st_q;
    logic [CW-1:0] half_m1;

    assign half_m1 = (CW'(DIV_BASE) << div_sel) - CW'(1);

    always_comb begin
        st_d     = st_q;
        ev       = '0;
        if (!en) begin
            st_d      = '0;
            st_d.sck  = cpol;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.sck  = cpol;
            st_d.cnt  = '0;
            st_d.tick = '0;
        end else if (st_q.busy) begin
            if (st_q.cnt == half_m1) begin
                st_d.cnt = '0;
                if (st_q.tick == TW'(TICKS)) begin
                    ev.fin    = 1'b1;
                    st_d.busy = 1'b0;
                end else begin
                    st_d.sck  = ~st_q.sck;
                    ev.lead   = ~st_q.tick[0];
                    ev.trail  = st_q.tick[0];
                    st_d.tick = st_q.tick + TW'(1);
                end
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else begin
            st_d.sck = cpol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sck  = st_q.sck;
    assign busy = st_q.busy;

endmodule

// File: rtl/spi_port_sfront.sv
module spi_port_sfront
    import spi_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    active,
    input  logic    cpol,
    input  logic    use_ss,
    input  logic    sck_i,
    input  logic    ss_n_i,
    input  logic    sdi_i,
    output sck_ev_t ev,
    output logic    sdi_s,
    output logic    selected
);
    localparam int S = SYNC_STAGES;

    typedef struct packed {
        logic [S-1:0] sck_sh;
        logic [S-1:0] ss_sh;
        logic [S-1:0] sdi_sh;
        logic         sck_p;
    } front_t;

    front_t st_d, st_q;
    logic   sck_s;
    logic   edge_seen;

    assign sck_s    = st_q.sck_sh[S-1];
    assign sdi_s    = st_q.sdi_sh[S-1];
    assign selected = ~use_ss | ~st_q.ss_sh[S-1];

    always_comb begin
        st_d        = st_q;
        st_d.sck_sh = {st_q.sck_sh[S-2:0], sck_i};
        st_d.ss_sh  = {st_q.ss_sh[S-2:0], ss_n_i};
        st_d.sdi_sh = {st_q.sdi_sh[S-2:0], sdi_i};
        st_d.sck_p  = sck_s;
        edge_seen   = active & selected & (sck_s != st_q.sck_p);
        ev.lead     = edge_seen & (st_q.sck_p == cpol);
        ev.trail    = edge_seen & (st_q.sck_p != cpol);
        ev.fin      = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ss_sh <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift
    import spi_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         cpha,
    input  logic         smp_late,
    input  sck_ev_t      ev,
    input  logic         sdi,
    output logic         sdo,
    output logic [W-1:0] rx_data,
    output logic         done,
    output logic         mid
);
    localparam int EW = $clog2(2 * W);
    localparam int SW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  tx;
        logic [W-1:0]  rx;
        logic          sdo;
        logic [EW-1:0] ecnt;
        logic [SW-1:0] scnt;
        logic          done;
    } shf_t;

    shf_t st_d, st_q;
    logic shift_now;
    logic sample_now;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        shift_now = cpha ? ev.lead : ev.trail;
        if (smp_late)
            sample_now = cpha ? ((ev.lead && st_q.ecnt != '0) || ev.fin) : ev.trail;
        else
            sample_now = cpha ? ev.trail : ev.lead;

        if (ev.lead || ev.trail)
            st_d.ecnt = (st_q.ecnt == EW'(2 * W - 1)) ? '0 : st_q.ecnt + EW'(1);

        if (shift_now) begin
            st_d.sdo = cpha ? st_q.tx[W-1] : st_q.tx[W-2];
            st_d.tx  = st_q.tx << 1;
        end

        if (sample_now) begin
            st_d.rx = {st_q.rx[W-2:0], sdi};
            if (st_q.scnt == SW'(W - 1)) begin
                st_d.scnt = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.scnt = st_q.scnt + SW'(1);
            end
        end

        if (clr) begin
            st_d.ecnt = '0;
            st_d.scnt = '0;
        end

        if (load) begin
            st_d.tx   = load_data;
            st_d.sdo  = load_data[W-1];
            st_d.ecnt = '0;
            st_d.scnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo     = st_q.sdo;
    assign rx_data = st_q.rx;
    assign done    = st_q.done;
    assign mid     = (st_q.ecnt != '0);

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DIV_BASE    = 1,
    parameter int DIVW        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_o,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       ss_n_i,
    input  logic       sdi_i,
    output logic       sdo_o,
    output logic       sdo_oe
);
    localparam int W = 8;

    typedef struct packed {
        ctrl_t        ctrl;
        logic         smp;
        logic         cpha;
        logic         bf;
        logic         irq;
        logic [W-1:0] buf_r;
    } port_t;

    port_t st_d, st_q;

    logic         master_en, slave_en, busy, data_wr, start, load, clr;
    logic         m_sck, m_busy, s_sdi, s_sel, sh_sdo, sh_done, sh_mid, sdi_mux;
    logic [W-1:0] sh_rx;
    sck_ev_t      m_ev, s_ev, ev;

    assign master_en = st_q.ctrl.en & ~st_q.ctrl.slave;
    assign slave_en  = st_q.ctrl.en & st_q.ctrl.slave;
    assign busy      = st_q.ctrl.slave ? sh_mid : m_busy;
    assign data_wr   = reg_wr && (reg_addr == ADDR_DATA);
    assign load      = data_wr && !busy;
    assign start     = load && master_en;
    assign clr       = ~st_q.ctrl.en | (st_q.ctrl.slave & ~s_sel);
    assign ev        = master_en ? m_ev : s_ev;
    assign sdi_mux   = st_q.ctrl.slave ? s_sdi : sdi_i;

    spi_port_clkgen #(.W(W), .DIV_BASE(DIV_BASE), .DIVW(DIVW)) i_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (master_en),
        .start   (start),
        .cpol    (st_q.ctrl.cpol),
        .div_sel (st_q.ctrl.div_sel),
        .sck     (m_sck),
        .busy    (m_busy),
        .ev      (m_ev)
    );

    spi_port_sfront #(.SYNC_STAGES(SYNC_STAGES)) i_sfront (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (slave_en),
        .cpol     (st_q.ctrl.cpol),
        .use_ss   (st_q.ctrl.use_ss),
        .sck_i    (sck_i),
        .ss_n_i   (ss_n_i),
        .sdi_i    (sdi_i),
        .ev       (s_ev),
        .sdi_s    (s_sdi),
        .selected (s_sel)
    );

    spi_port_shift #(.W(W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .load      (load),
        .load_data (reg_wdata),
        .cpha      (st_q.cpha),
        .smp_late  (st_q.smp & ~st_q.ctrl.slave),
        .ev        (ev),
        .sdi       (sdi_mux),
        .sdo       (sh_sdo),
        .rx_data   (sh_rx),
        .done      (sh_done),
        .mid       (sh_mid)
    );

    always_comb begin
        st_d = st_q;
        // a read of the data register acknowledges the byte
        if (reg_rd && reg_addr == ADDR_DATA) begin
            st_d.bf  = 1'b0;
            st_d.irq = 1'b0;
        end
        // completed byte: buffer it, or flag overflow and keep the old one
        if (sh_done) begin
            st_d.irq = 1'b1;
            if (st_q.bf) begin
                st_d.ctrl.ovf = 1'b1;
            end else begin
                st_d.buf_r = sh_rx;
                st_d.bf    = 1'b1;
            end
        end
        if (reg_wr) begin
            unique case (reg_addr)
                ADDR_CTRL: st_d.ctrl = ctrl_t'(reg_wdata);
                ADDR_STAT: begin
                    st_d.smp  = reg_wdata[7];
                    st_d.cpha = reg_wdata[6];
                end
                ADDR_DATA: begin
                    if (busy) st_d.ctrl.wcol = 1'b1;
                    else      st_d.buf_r     = reg_wdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = st_q.ctrl;
            ADDR_STAT: reg_rdata = {st_q.smp, st_q.cpha, 3'b000, st_q.irq, busy, st_q.bf};
            ADDR_DATA: reg_rdata = st_q.buf_r;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq_o  = st_q.irq;
    assign sck_o  = m_sck;
    assign sck_oe = master_en;
    assign sdo_o  = sh_sdo;
    assign sdo_oe = master_en | (slave_en & s_sel);

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_addr,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       busy,
    input logic       wcol,
    input logic       bf,
    input logic       done,
    input logic [7:0] buf_r,
    input logic       master_en,
    input logic       m_busy,
    input logic       sck_o,
    input logic       cpol,
    input logic       slave_en,
    input logic       s_sel,
    input logic       sh_mid
);
    logic data_wr, data_rd, ctrl_wr;
    assign data_wr = reg_wr && reg_addr == 2'd2;
    assign data_rd = reg_rd && reg_addr == 2'd2;
    assign ctrl_wr = reg_wr && reg_addr == 2'd0;

    assert_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && busy |=> wcol);

    assert_wcol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wcol && !ctrl_wr |=> wcol);

    assert_keep_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done && bf && !data_wr && !data_rd |=> $stable(buf_r));

    assert_bf_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> bf);

    assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        master_en && !m_busy |=> sck_o == $past(cpol));

    assert_deselect_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        slave_en && !s_sel |=> !sh_mid);

endmodule

bind spi_port spi_port_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .busy      (busy),
    .wcol      (st_q.ctrl.wcol),
    .bf        (st_q.bf),
    .done      (sh_done),
    .buf_r     (st_q.buf_r),
    .master_en (master_en),
    .m_busy    (m_busy),
    .sck_o     (sck_o),
    .cpol      (st_q.ctrl.cpol),
    .slave_en  (slave_en),
    .s_sel     (s_sel),
    .sh_mid    (sh_mid)
);

// File: tb/test_spi_port.sv
module test_spi_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_o, sck_o, sck_oe, sdo_o, sdo_oe;
    logic       tb_sck = 1'b0, tb_ss_n = 1'b1, tb_sdi = 1'b0, tb_ext = 1'b0;
    logic       sdi_w;

    assign sdi_w = tb_ext ? tb_sdi : sdo_o;

    always #2 clk = ~clk;

    spi_port i_spi_port (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
        .sck_i(tb_sck), .sck_o(sck_o), .sck_oe(sck_oe), .ss_n_i(tb_ss_n),
        .sdi_i(sdi_w), .sdo_o(sdo_o), .sdo_oe(sdo_oe)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // serial clock monitor for master transfers
    logic       mon_clr = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
    int         mon_half = 1;
    logic       mon_prev;
    logic [7:0] mon_byte;
    int         mon_tog, mon_gap, mon_gap_err;

    always @(negedge clk) begin
        if (mon_clr) begin
            mon_prev = sck_o; mon_byte = '0; mon_tog = 0; mon_gap = 0; mon_gap_err = 0;
        end else if (sck_o != mon_prev) begin
            if (mon_tog != 0 && mon_gap != mon_half) mon_gap_err++;
            if ((mon_prev == mon_cpol) != mon_cpha) mon_byte = {mon_byte[6:0], sdo_o};
            mon_tog++;
            mon_gap = 1;
            mon_prev = sck_o;
        end else begin
            mon_gap++;
        end
    end

    task automatic mxfer(input logic cp, input logic ph, input logic sm, input int dv,
                         input logic [7:0] tx);
        logic [7:0] d;
        wr(0, 8'h20 | (8'(cp) << 4) | 8'(dv));
        wr(1, {sm, ph, 6'b0});
        mon_cpol = cp; mon_cpha = ph; mon_half = 1 << dv;
        mon_clr = 1'b1; idle(2); mon_clr = 1'b0;
        wr(2, tx);
        rd(1, d);
        chk("R5 busy during transfer", int'(d[1]), 1);
        idle(17 * (1 << dv) + 6);
        chk("R4 sck edge count", mon_tog, 16);
        chk("R4 half period length", mon_gap_err, 0);
        chk("R4 sck rests at polarity", int'(sck_o), int'(cp));
        chk("R1 R2 sdo bits msb first", int'(mon_byte), int'(tx));
        rd(1, d);
        chk("R6 status after byte", int'(d), int'({sm, ph, 6'b000101}));
        chk("R6 irq_o set", int'(irq_o), 1);
        rd(2, d);
        chk("R3 looped byte received", int'(d), int'(tx));
        rd(1, d);
        chk("R6 read clears full and flag", int'(d[2:0]), 0);
    endtask

    task automatic sxfer(input logic cp, input logic ph, input logic [7:0] tx,
                         input logic [7:0] rx_in);
        logic [7:0] d, got;
        got = '0;
        wr(0, 8'h00);
        tb_ss_n = 1'b1; tb_sck = cp; tb_ext = 1'b1;
        idle(4);
        wr(0, 8'h2C | (8'(cp) << 4));
        wr(1, {1'b0, ph, 6'b0});
        wr(2, tx);
        chk("R11 sdo disabled while deselected", int'(sdo_oe), 0);
        tb_ss_n = 1'b0;
        if (!ph) tb_sdi = rx_in[7];
        idle(6);
        chk("R11 sdo enabled when selected", int'(sdo_oe), 1);
        for (int b = 7; b >= 0; b--) begin
            if (!ph) begin
                tb_sdi = rx_in[b];
                idle(6);
                got = {got[6:0], sdo_o};
                tb_sck = ~cp;
                idle(6);
                tb_sck = cp;
            end else begin
                tb_sck = ~cp;
                tb_sdi = rx_in[b];
                idle(6);
                got = {got[6:0], sdo_o};
                tb_sck = cp;
                idle(6);
            end
        end
        idle(8);
        tb_ss_n = 1'b1;
        idle(4);
        chk("R10 slave sent byte", int'(got), int'(tx));
        rd(1, d);
        chk("R10 slave byte buffered", int'(d[0]), 1);
        rd(2, d);
        chk("R10 slave received byte", int'(d), int'(rx_in));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] pats [3];
        pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h81;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // reset state
        rd(0, d); chk("R9 reset control", int'(d), 0);
        rd(1, d); chk("R9 reset status", int'(d), 0);
        rd(2, d); chk("R9 reset data", int'(d), 0);
        chk("R4 reset output enables", int'({sck_oe, sdo_oe, irq_o}), 0);

        // register access
        wr(1, 8'hFF); rd(1, d); chk("R9 status low bits read-only", int'(d), 8'hC0);
        wr(0, 8'hDF); rd(0, d); chk("R9 control read back", int'(d), 8'hDF);
        wr(0, 8'h00); wr(1, 8'h00);

        // master sweep over polarity, phase, late sample and divider
        for (int cp = 0; cp < 2; cp++)
            for (int ph = 0; ph < 2; ph++)
                for (int sm = 0; sm < 2; sm++)
                    for (int dv = 0; dv < 2; dv++)
                        for (int i = 0; i < 3; i++)
                            mxfer(cp[0], ph[0], sm[0], dv, pats[i]);

        // write collision
        wr(0, 8'h21); wr(1, 8'h00);
        wr(2, 8'h5A);
        idle(8);
        wr(2, 8'hFF);
        idle(40);
        rd(0, d); chk("R8 collision bit set and sticky", int'(d), 8'hA1);
        rd(2, d); chk("R8 colliding write discarded", int'(d), 8'h5A);
        wr(0, 8'h21);
        rd(0, d); chk("R8 collision cleared by software", int'(d), 8'h21);

        // overflow: external data all ones
        tb_ext = 1'b1; tb_sdi = 1'b1;
        wr(2, 8'h11); idle(40);
        wr(2, 8'h22); idle(40);
        rd(0, d); chk("R7 overflow bit", int'(d[6]), 1);
        rd(1, d); chk("R7 buffer still full", int'(d[0]), 1);
        rd(2, d); chk("R7 old contents kept", int'(d), 8'h22);
        wr(0, 8'h00);
        tb_ext = 1'b0;

        // slave sweep
        for (int cp = 0; cp < 2; cp++)
            for (int ph = 0; ph < 2; ph++) begin
                sxfer(cp[0], ph[0], 8'hC6, 8'h39);
                sxfer(cp[0], ph[0], 8'h1E, 8'hB4);
            end

        // cut-off byte then a full one
        wr(0, 8'h00); tb_sck = 1'b0; tb_ext = 1'b1; idle(4);
        wr(0, 8'h2C); wr(1, 8'h00); wr(2, 8'h77);
        tb_ss_n = 1'b0; tb_sdi = 1'b1; idle(6);
        for (int b = 0; b < 3; b++) begin
            tb_sck = 1'b1; idle(6); tb_sck = 1'b0; idle(6);
        end
        tb_ss_n = 1'b1; idle(6);
        chk("R11 output off after deselect", int'(sdo_oe), 0);
        sxfer(1'b0, 1'b0, 8'hC3, 8'h5A);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule